// File: doc/BRIEF.md
# Pseudo-SRAM Page-Read Host Controller

This block sits on the host side of an asynchronous pseudo-static RAM that has a 20-bit word address, a 16-bit data bus and separate strobes for the low and high bytes. A client hands it one request at a time over a valid/ready handshake. A request is a single-word write or a read of one to four consecutive words. The controller then sequences chip-enable, output-enable, write-enable and the byte strobes. Every interval is a whole number of clock cycles, derived by rounding nanosecond parameters up to the clock period.

When the page-read enable input is high, the words of a read that fall in one aligned four-word page share a single chip-enable low period. The first word of the period takes the random access time. Each later word takes only the shorter page time, and only the two lowest address bits move. The controller ends the chip-enable period and starts a fresh random access in two cases: the next word lies in another page, or one more page word would take chip-enable past its maximum low time. That limit leaves the memory room for its hidden refresh. With page reads disabled, and for all writes, each word gets its own chip-enable period. The sleep control toward the memory is held inactive (high) at all times.

Top module: `psram_page_ctrl`

## Requirements
- R1: During and after reset, with no request pending, chip-enable, output-enable and write-enable and both byte strobes are high (inactive), the data bus is not driven, the sleep output is high, req_ready is 1 and rd_valid is 0.
- R2: With page_en low, every word of a read burst gets its own chip-enable low period of exactly RAND cycles (4 at the default 20 ns clock). Consecutive rd_valid pulses are RAND+CEH cycles apart (5).
- R3: With page_en high, the words of a burst that stay inside one aligned page share one chip-enable low period. Each word after the first is returned PAGE cycles (2) after the previous one.
- R4: A burst that crosses from address bits [1:0]=3 to the next page is split into separate chip-enable periods. While chip-enable stays low, address bits [19:2] do not change. Address 0xFFFFF is followed by 0x00000.
- R5: Chip-enable never stays low for more than CEMAX cycles. When one more page word would exceed this, chip-enable is released and the next word starts with a new random access.
- R6: Between two chip-enable low periods, chip-enable is high for at least CEH cycles.
- R7: A write with a non-zero byte mask uses one chip-enable low period in which write-enable is low for exactly WP cycles (3). req_be[0] selects the low byte strobe and req_be[1] selects the high one. Write data is driven only then. Output-enable is never low together with write-enable or a driven data bus.
- R8: A write with req_be = 2'b00 produces no chip-enable or write-enable activity, leaves memory unchanged, and still completes with a done pulse.
- R9: A read returns req_len+1 words in ascending address order, one rd_valid pulse per word. Each request ends with exactly one done pulse.
- R10: req_ready is high only while the controller is idle. A request is taken when req_valid and req_ready are both high. req_ready is low while an access is in progress, and chip-enable is never low while req_ready is high.
- R11: req_len is ignored for writes: a write always stores exactly one word, at req_addr.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| page_en | input | 1 | Allows page-mode reads when 1 |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Controller idle, request is taken this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 20 | Word address of the first word |
| req_len | input | 2 | Read words minus one; ignored for writes |
| req_be | input | 2 | Write byte mask, bit 0 = low byte |
| req_wdata | input | 16 | Write data |
| rd_valid | output | 1 | One pulse per returned read word |
| rd_data | output | 16 | Returned read word |
| done | output | 1 | Pulse when a request has fully finished |
| mem_addr | output | 20 | Memory word address |
| mem_ce_n | output | 1 | Chip enable, active low |
| mem_oe_n | output | 1 | Output enable, active low |
| mem_we_n | output | 1 | Write enable, active low |
| mem_lb_n | output | 1 | Low byte strobe, active low |
| mem_ub_n | output | 1 | High byte strobe, active low |
| mem_sleep_n | output | 1 | Sleep control, held high |
| mem_dq_out | output | 16 | Data toward the memory |
| mem_dq_oe | output | 1 | Drive enable for mem_dq_out |
| mem_dq_in | input | 16 | Data from the memory |

## Verification
The hardest case to reach from the ports is the forced chip-enable break inside one page. It only happens when the accumulated low time, not a page boundary, stops the burst. The bench therefore builds the controller with a maximum low time of nine cycles. A four-word aligned page read then runs out of budget after three words, and the bench checks that the fourth word comes in a new chip-enable period after a random-access delay. Page-boundary splits are driven from several start offsets, including the top address, so that the two kinds of split can be told apart by chip-enable counts and word spacing.

// File: rtl/psram_pkg.sv
package psram_pkg;

    localparam int PAGE_W = 2;

    typedef enum logic [2:0] {
        ST_IDLE    = 3'd0,
        ST_RD_RAND = 3'd1,
        ST_RD_PAGE = 3'd2,
        ST_WRITE   = 3'd3,
        ST_GAP     = 3'd4
    } ctrl_state_t;

    typedef struct packed {
        logic ce_n;
        logic oe_n;
        logic we_n;
        logic lb_n;
        logic ub_n;
        logic dq_oe;
    } strobe_t;

    function automatic int ns_to_cyc(input int ns, input int clk_ns);
        int c;
        c = (ns + clk_ns - 1) / clk_ns;
        if (c < 1) c = 1;
        return c;
    endfunction

    function automatic int max2(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

    function automatic strobe_t strobes_for(input ctrl_state_t st, input logic [1:0] be);
        strobe_t s;
        s = '{ce_n: 1'b1, oe_n: 1'b1, we_n: 1'b1, lb_n: 1'b1, ub_n: 1'b1, dq_oe: 1'b0};
        case (st)
            ST_RD_RAND, ST_RD_PAGE: begin
                s.ce_n = 1'b0;
                s.oe_n = 1'b0;
                s.lb_n = 1'b0;
                s.ub_n = 1'b0;
            end
            ST_WRITE: begin
                s.ce_n  = 1'b0;
                s.we_n  = 1'b0;
                s.lb_n  = ~be[0];
                s.ub_n  = ~be[1];
                s.dq_oe = 1'b1;
            end
            default: ;
        endcase
        return s;
    endfunction

endpackage

// File: rtl/psram_step_timer.sv
module psram_step_timer #(
    parameter int W = 3
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         load,
    input  logic [W-1:0] load_val,
    output logic         last
);
    logic [W-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt <= '0;
        end else if (load) begin
            cnt <= load_val;
        end else if (cnt != '0) begin
            cnt <= cnt - 1'b1;
        end
    end

    assign last = (cnt == '0);
endmodule

// File: rtl/psram_ce_window.sv
module psram_ce_window #(
    parameter int CEMAX_CYC = 500,
    parameter int PAGE_CYC  = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic ce_n,
    output logic page_fits
);
    localparam int CW = $clog2(CEMAX_CYC + PAGE_CYC + 2);

    logic [CW-1:0] low_cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            low_cnt <= '0;
        end else if (!ce_n) begin
            low_cnt <= low_cnt + 1'b1;
        end else begin
            low_cnt <= '0;
        end
    end

    // low_cnt+1 cycles spent so far in this period, including the current one
    assign page_fits = (int'(low_cnt) + 1 + PAGE_CYC) <= CEMAX_CYC;
endmodule

// File: rtl/psram_addr_walk.sv
module psram_addr_walk #(
    parameter int AW = 20,
    parameter int PW = 2
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          load,
    input  logic [AW-1:0] load_addr,
    input  logic [PW-1:0] load_left,
    input  logic          step,
    output logic [AW-1:0] addr,
    output logic          last_word,
    output logic          page_end
);
    logic [PW-1:0] left;

    always_ff @(posedge clk) begin
        if (rst) begin
            addr <= '0;
            left <= '0;
        end else if (load) begin
            addr <= load_addr;
            left <= load_left;
        end else if (step) begin
            addr <= addr + 1'b1;
            left <= left - 1'b1;
        end
    end

    assign last_word = (left == '0);
    assign page_end  = &addr[PW-1:0];
endmodule

// File: rtl/psram_page_ctrl.sv
module psram_page_ctrl
    import psram_pkg::*;
#(
    parameter int ADDR_W        = 20,
    parameter int DATA_W        = 16,
    parameter int CLK_PERIOD_NS = 20,
    parameter int RAND_NS       = 70,
    parameter int PAGE_NS       = 25,
    parameter int WP_NS         = 50,
    parameter int CEH_NS        = 10,
    parameter int CEMAX_NS      = 10000
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              page_en,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [PAGE_W-1:0] req_len,
    input  logic [1:0]        req_be,
    input  logic [DATA_W-1:0] req_wdata,
    output logic              rd_valid,
    output logic [DATA_W-1:0] rd_data,
    output logic              done,
    output logic [ADDR_W-1:0] mem_addr,
    output logic              mem_ce_n,
    output logic              mem_oe_n,
    output logic              mem_we_n,
    output logic              mem_lb_n,
    output logic              mem_ub_n,
    output logic              mem_sleep_n,
    output logic [DATA_W-1:0] mem_dq_out,
    output logic              mem_dq_oe,
    input  logic [DATA_W-1:0] mem_dq_in
);
    localparam int RAND_CYC  = ns_to_cyc(RAND_NS, CLK_PERIOD_NS);
    localparam int PAGE_CYC  = ns_to_cyc(PAGE_NS, CLK_PERIOD_NS);
    localparam int WP_CYC    = ns_to_cyc(WP_NS, CLK_PERIOD_NS);
    localparam int CEH_CYC   = ns_to_cyc(CEH_NS, CLK_PERIOD_NS);
    localparam int CEMAX_CYC = ns_to_cyc(CEMAX_NS, CLK_PERIOD_NS);
    localparam int TMAX      = max2(max2(RAND_CYC, PAGE_CYC), max2(WP_CYC, CEH_CYC));
    localparam int TW        = $clog2(TMAX + 1);

    localparam logic [TW-1:0] RAND_LD = TW'(RAND_CYC - 1);
    localparam logic [TW-1:0] PAGE_LD = TW'(PAGE_CYC - 1);
    localparam logic [TW-1:0] WP_LD   = TW'(WP_CYC - 1);
    localparam logic [TW-1:0] CEH_LD  = TW'(CEH_CYC - 1);

    ctrl_state_t       state, state_nx;
    strobe_t           strb;
    logic [1:0]        be_q;
    logic [DATA_W-1:0] wdata_q;
    logic              pend_q;

    logic              t_load, t_last;
    logic [TW-1:0]     t_val;
    logic              w_load, w_step, last_word, page_end;
    logic [PAGE_W-1:0] w_left;
    logic              page_fits;
    logic              cap, pend_set, pend_clr, done_nx;

    psram_step_timer #(.W(TW)) u_timer (
        .clk      (clk),
        .rst      (rst),
        .load     (t_load),
        .load_val (t_val),
        .last     (t_last)
    );

    psram_addr_walk #(.AW(ADDR_W), .PW(PAGE_W)) u_walk (
        .clk       (clk),
        .rst       (rst),
        .load      (w_load),
        .load_addr (req_addr),
        .load_left (w_left),
        .step      (w_step),
        .addr      (mem_addr),
        .last_word (last_word),
        .page_end  (page_end)
    );

    psram_ce_window #(.CEMAX_CYC(CEMAX_CYC), .PAGE_CYC(PAGE_CYC)) u_window (
        .clk       (clk),
        .rst       (rst),
        .ce_n      (mem_ce_n),
        .page_fits (page_fits)
    );

    assign w_left = req_write ? '0 : req_len;

    always_comb begin
        state_nx = state;
        t_load   = 1'b0;
        t_val    = '0;
        w_load   = 1'b0;
        w_step   = 1'b0;
        cap      = 1'b0;
        pend_set = 1'b0;
        pend_clr = 1'b0;
        done_nx  = 1'b0;
        case (state)
            ST_IDLE: begin
                if (req_valid) begin
                    w_load = 1'b1;
                    t_load = 1'b1;
                    if (!req_write) begin
                        state_nx = ST_RD_RAND;
                        t_val    = RAND_LD;
                    end else if (req_be != 2'b00) begin
                        state_nx = ST_WRITE;
                        t_val    = WP_LD;
                    end else begin
                        state_nx = ST_GAP;
                        t_val    = CEH_LD;
                    end
                end
            end
            ST_RD_RAND, ST_RD_PAGE: begin
                if (t_last) begin
                    cap    = 1'b1;
                    t_load = 1'b1;
                    if (last_word) begin
                        state_nx = ST_GAP;
                        t_val    = CEH_LD;
                    end else begin
                        w_step = 1'b1;
                        if (page_en && !page_end && page_fits) begin
                            state_nx = ST_RD_PAGE;
                            t_val    = PAGE_LD;
                        end else begin
                            state_nx = ST_GAP;
                            t_val    = CEH_LD;
                            pend_set = 1'b1;
                        end
                    end
                end
            end
            ST_WRITE: begin
                if (t_last) begin
                    state_nx = ST_GAP;
                    t_load   = 1'b1;
                    t_val    = CEH_LD;
                end
            end
            ST_GAP: begin
                if (t_last) begin
                    if (pend_q) begin
                        state_nx = ST_RD_RAND;
                        t_load   = 1'b1;
                        t_val    = RAND_LD;
                        pend_clr = 1'b1;
                    end else begin
                        state_nx = ST_IDLE;
                        done_nx  = 1'b1;
                    end
                end
            end
            default: state_nx = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state    <= ST_IDLE;
            pend_q   <= 1'b0;
            be_q     <= 2'b00;
            wdata_q  <= '0;
            rd_valid <= 1'b0;
            rd_data  <= '0;
            done     <= 1'b0;
        end else begin
            state    <= state_nx;
            rd_valid <= cap;
            done     <= done_nx;
            if (cap) rd_data <= mem_dq_in;
            if (pend_set) pend_q <= 1'b1;
            else if (pend_clr) pend_q <= 1'b0;
            if (state == ST_IDLE && req_valid) begin
                be_q    <= req_be;
                wdata_q <= req_wdata;
            end
        end
    end

    assign strb        = strobes_for(state, be_q);
    assign req_ready   = (state == ST_IDLE);
    assign mem_ce_n    = strb.ce_n;
    assign mem_oe_n    = strb.oe_n;
    assign mem_we_n    = strb.we_n;
    assign mem_lb_n    = strb.lb_n;
    assign mem_ub_n    = strb.ub_n;
    assign mem_dq_oe   = strb.dq_oe;
    assign mem_dq_out  = wdata_q;
    assign mem_sleep_n = 1'b1;
endmodule

// File: rtl/psram_page_ctrl_chk.sv
module psram_page_ctrl_chk
    import psram_pkg::*;
#(
    parameter int ADDR_W        = 20,
    parameter int CLK_PERIOD_NS = 20,
    parameter int CEH_NS        = 10,
    parameter int CEMAX_NS      = 10000
) (
    input logic              clk,
    input logic              rst,
    input logic              req_ready,
    input logic [ADDR_W-1:0] mem_addr,
    input logic              mem_ce_n,
    input logic              mem_oe_n,
    input logic              mem_we_n,
    input logic              mem_lb_n,
    input logic              mem_ub_n,
    input logic              mem_dq_oe
);
    localparam int CEH_CYC   = ns_to_cyc(CEH_NS, CLK_PERIOD_NS);
    localparam int CEMAX_CYC = ns_to_cyc(CEMAX_NS, CLK_PERIOD_NS);

    int low_run;
    int high_run;

    always_ff @(posedge clk) begin
        if (rst) begin
            low_run  <= 0;
            high_run <= CEH_CYC;
        end else if (!mem_ce_n) begin
            low_run  <= low_run + 1;
            high_run <= 0;
        end else begin
            low_run  <= 0;
            high_run <= (high_run < CEH_CYC) ? high_run + 1 : CEH_CYC;
        end
    end

    // R5
    ce_low_cap_chk: assert property (@(posedge clk) disable iff (rst)
        !mem_ce_n |-> (low_run < CEMAX_CYC));

    // R6
    ce_high_gap_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(mem_ce_n) |-> (high_run >= CEH_CYC));

    // R4
    page_addr_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (!mem_ce_n && $past(!mem_ce_n)) |-> (mem_addr[ADDR_W-1:PAGE_W] == $past(mem_addr[ADDR_W-1:PAGE_W])));

    // R7
    we_gating_chk: assert property (@(posedge clk) disable iff (rst)
        !mem_we_n |-> (!mem_ce_n && (!mem_lb_n || !mem_ub_n)));

    // R7
    bus_contention_chk: assert property (@(posedge clk) disable iff (rst)
        (mem_dq_oe || !mem_we_n) |-> mem_oe_n);

    // R10
    idle_ce_chk: assert property (@(posedge clk) disable iff (rst)
        req_ready |-> mem_ce_n);
endmodule

bind psram_page_ctrl psram_page_ctrl_chk #(
    .ADDR_W        (ADDR_W),
    .CLK_PERIOD_NS (CLK_PERIOD_NS),
    .CEH_NS        (CEH_NS),
    .CEMAX_NS      (CEMAX_NS)
) i_chk (
    .clk       (clk),
    .rst       (rst),
    .req_ready (req_ready),
    .mem_addr  (mem_addr),
    .mem_ce_n  (mem_ce_n),
    .mem_oe_n  (mem_oe_n),
    .mem_we_n  (mem_we_n),
    .mem_lb_n  (mem_lb_n),
    .mem_ub_n  (mem_ub_n),
    .mem_dq_oe (mem_dq_oe)
);

// File: tb/test_psram_page_ctrl.sv
module test_psram_page_ctrl;
    // cycle counts at a 20 ns clock, worked out by hand
    localparam int T_RAND  = 4;
    localparam int T_PAGE  = 2;
    localparam int T_WP    = 3;
    localparam int T_CEH   = 1;
    localparam int T_CEMAX = 9;

    // {tag, page_en, len, expected chip-enable periods, address}
    localparam logic [35:0] VEC [9] = '{
        36'h2_0_0_1_00010,  // R2 single word
        36'h2_0_3_4_00010,  // R2 four random cycles
        36'h3_1_2_1_00010,  // R3 one period
        36'h5_1_3_2_00010,  // R5 cap breaks after three words
        36'h4_1_3_2_00012,  // R4 boundary after two words
        36'h4_1_1_2_00013,  // R4 boundary after one word
        36'h3_1_2_1_00021,  // R3 unaligned start inside page
        36'h2_0_2_3_0002E,  // R2 across page, page off
        36'h4_1_1_2_FFFFF   // R4 top address wraps
    };

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        page_en = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic        req_write = 1'b0;
    logic [19:0] req_addr = '0;
    logic [1:0]  req_len = '0;
    logic [1:0]  req_be = '0;
    logic [15:0] req_wdata = '0;
    logic        rd_valid;
    logic [15:0] rd_data;
    logic        done;
    logic [19:0] mem_addr;
    logic        mem_ce_n, mem_oe_n, mem_we_n, mem_lb_n, mem_ub_n, mem_sleep_n;
    logic [15:0] mem_dq_out;
    logic        mem_dq_oe;
    logic [15:0] mem_dq_in;

    always #10 clk = ~clk;

    psram_page_ctrl #(.CEMAX_NS(180)) i_psram_page_ctrl (
        .clk, .rst, .page_en, .req_valid, .req_ready, .req_write, .req_addr,
        .req_len, .req_be, .req_wdata, .rd_valid, .rd_data, .done, .mem_addr,
        .mem_ce_n, .mem_oe_n, .mem_we_n, .mem_lb_n, .mem_ub_n, .mem_sleep_n,
        .mem_dq_out, .mem_dq_oe, .mem_dq_in
    );

    function automatic logic [15:0] pat(input logic [19:0] a);
        return {a[7:0] ^ 8'hC3, a[7:0]};
    endfunction

    // memory model and monitor
    logic [15:0] mdl [256];
    assign mem_dq_in = (!mem_ce_n && !mem_oe_n) ? mdl[mem_addr[7:0]] : 16'h0000;

    logic        mon_clr = 1'b0;
    logic        prev_ce;
    int          cyc, falls, lrun, hrun, max_low, min_gap, we_cyc, rd_n, done_n;
    logic [15:0] rd_dat [8];
    int          rd_t [8];

    always @(negedge clk) begin
        cyc = cyc + 1;
        if (rst) begin
            for (int i = 0; i < 256; i++) mdl[i] = pat(20'(i));
            prev_ce = 1'b1;
        end
        if (rst || mon_clr) begin
            falls = 0; lrun = 0; hrun = 0; max_low = 0; min_gap = 1000;
            we_cyc = 0; rd_n = 0; done_n = 0;
        end else begin
            if (!mem_ce_n) begin
                if (prev_ce) begin
                    if (falls > 0 && hrun < min_gap) min_gap = hrun;
                    falls = falls + 1;
                end
                lrun = lrun + 1;
                if (lrun > max_low) max_low = lrun;
                hrun = 0;
            end else begin
                lrun = 0;
                hrun = hrun + 1;
            end
            prev_ce = mem_ce_n;
            if (!mem_we_n && !mem_ce_n) begin
                we_cyc = we_cyc + 1;
                if (!mem_lb_n) mdl[mem_addr[7:0]][7:0]  = mem_dq_out[7:0];
                if (!mem_ub_n) mdl[mem_addr[7:0]][15:8] = mem_dq_out[15:8];
            end
            if (rd_valid && rd_n < 8) begin
                rd_dat[rd_n] = rd_data;
                rd_t[rd_n]   = cyc;
                rd_n = rd_n + 1;
            end
            if (done) done_n = done_n + 1;
        end
    end

    int  checks = 0;
    int  errors = 0;
    int  wd_err = 0;
    bit  finished = 0;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic run_req(input logic wr, input logic [19:0] a, input logic [1:0] l,
                           input logic [1:0] be, input logic [15:0] wd, input logic pg);
        int t;
        @(posedge clk);
        mon_clr = 1'b1;
        @(negedge clk);
        @(posedge clk);
        mon_clr = 1'b0;
        @(negedge clk);
        req_valid = 1'b1; req_write = wr; req_addr = a; req_len = l;
        req_be = be; req_wdata = wd; page_en = pg;
        @(negedge clk);
        req_valid = 1'b0;
        // R10: busy once taken
        chk(req_ready == 1'b0, "R10 ready while busy", req_ready, 0);
        t = 0;
        while (done_n == 0 && t < 400) begin
            @(posedge clk);
            t++;
        end
        chk(t < 400, "R9 request completion", t, 0);
        @(posedge clk);
        @(posedge clk);
    endtask

    initial begin
        #(20 * 150000);
        if (!finished) begin
            wd_err = 1;
            $display("FAIL watchdog expired actual=1 expected=0");
            $display("  CHECKS %0d ERRORS %0d", checks + 1, errors + wd_err);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1 during reset
        chk(mem_ce_n && mem_oe_n && mem_we_n && mem_lb_n && mem_ub_n && !mem_dq_oe,
            "R1 strobes in reset", {mem_ce_n, mem_oe_n, mem_we_n, mem_lb_n, mem_ub_n, mem_dq_oe}, 6'b111110);
        rst = 1'b0;
        repeat (2) @(negedge clk);
        // R1 after reset
        chk(mem_ce_n && mem_oe_n && mem_we_n && mem_lb_n && mem_ub_n && !mem_dq_oe,
            "R1 strobes idle", {mem_ce_n, mem_oe_n, mem_we_n, mem_lb_n, mem_ub_n, mem_dq_oe}, 6'b111110);
        chk(req_ready && !rd_valid && mem_sleep_n, "R1 ready/valid/sleep",
            {req_ready, rd_valid, mem_sleep_n}, 3'b101);

        // table of read bursts: R2 R3 R4 R5 R9
        for (int k = 0; k < 9; k++) begin
            logic [35:0] v;
            string tg;
            v = VEC[k];
            tg = $sformatf("R%0d", v[35:32]);
            run_req(1'b0, v[19:0], v[25:24], 2'b11, 16'h0, v[28]);
            chk(rd_n == int'(v[25:24]) + 1, "R9 word count", rd_n, int'(v[25:24]) + 1);
            for (int i = 0; i <= int'(v[25:24]); i++)
                chk(rd_dat[i] == pat(v[19:0] + 20'(i)), "R9 word data", rd_dat[i], pat(v[19:0] + 20'(i)));
            chk(falls == int'(v[23:20]), {tg, " chip-enable periods"}, falls, v[23:20]);
            chk(max_low <= T_CEMAX, "R5 low time", max_low, T_CEMAX);
            chk(done_n == 1, "R9 done pulses", done_n, 1);
        end

        // R3 page spacing
        run_req(1'b0, 20'h00040, 2'd2, 2'b11, 16'h0, 1'b1);
        chk(rd_t[1] - rd_t[0] == T_PAGE, "R3 spacing 1", rd_t[1] - rd_t[0], T_PAGE);
        chk(rd_t[2] - rd_t[1] == T_PAGE, "R3 spacing 2", rd_t[2] - rd_t[1], T_PAGE);
        chk(max_low == T_RAND + 2 * T_PAGE, "R3 low time", max_low, T_RAND + 2 * T_PAGE);

        // R2 random spacing and period length
        run_req(1'b0, 20'h00044, 2'd1, 2'b11, 16'h0, 1'b0);
        chk(rd_t[1] - rd_t[0] == T_RAND + T_CEH, "R2 spacing", rd_t[1] - rd_t[0], T_RAND + T_CEH);
        chk(max_low == T_RAND, "R2 low time", max_low, T_RAND);

        // R6 gap between periods
        run_req(1'b0, 20'h00048, 2'd2, 2'b11, 16'h0, 1'b0);
        chk(min_gap >= T_CEH, "R6 high gap", min_gap, T_CEH);

        // R5 forced break spacing
        run_req(1'b0, 20'h00050, 2'd3, 2'b11, 16'h0, 1'b1);
        chk(rd_t[2] - rd_t[1] == T_PAGE, "R5 page before cap", rd_t[2] - rd_t[1], T_PAGE);
        chk(rd_t[3] - rd_t[2] == T_RAND + T_CEH, "R5 restart after cap", rd_t[3] - rd_t[2], T_RAND + T_CEH);
        chk(max_low == T_RAND + 2 * T_PAGE, "R5 longest period", max_low, T_RAND + 2 * T_PAGE);

        // R7 full write then read back
        run_req(1'b1, 20'h00055, 2'd0, 2'b11, 16'h1234, 1'b0);
        chk(we_cyc == T_WP, "R7 write pulse", we_cyc, T_WP);
        chk(falls == 1 && rd_n == 0, "R7 one period, no read", falls, 1);
        run_req(1'b0, 20'h00055, 2'd0, 2'b11, 16'h0, 1'b0);
        chk(rd_dat[0] == 16'h1234, "R7 full word", rd_dat[0], 16'h1234);

        // R7 low byte only
        run_req(1'b1, 20'h00055, 2'd0, 2'b01, 16'hABCD, 1'b0);
        run_req(1'b0, 20'h00055, 2'd0, 2'b11, 16'h0, 1'b0);
        chk(rd_dat[0] == 16'h12CD, "R7 low byte", rd_dat[0], 16'h12CD);

        // R7 high byte only
        run_req(1'b1, 20'h00055, 2'd0, 2'b10, 16'h77EE, 1'b0);
        run_req(1'b0, 20'h00055, 2'd0, 2'b11, 16'h0, 1'b0);
        chk(rd_dat[0] == 16'h77CD, "R7 high byte", rd_dat[0], 16'h77CD);

        // R8 empty byte mask
        run_req(1'b1, 20'h00055, 2'd0, 2'b00, 16'h0000, 1'b0);
        chk(falls == 0 && we_cyc == 0, "R8 no strobes", falls + we_cyc, 0);
        chk(done_n == 1, "R8 completes", done_n, 1);
        run_req(1'b0, 20'h00055, 2'd0, 2'b11, 16'h0, 1'b0);
        chk(rd_dat[0] == 16'h77CD, "R8 memory unchanged", rd_dat[0], 16'h77CD);

        // R11 write ignores length
        run_req(1'b1, 20'h00060, 2'd3, 2'b11, 16'hBEEF, 1'b1);
        chk(falls == 1 && we_cyc == T_WP, "R11 single write", falls * 16 + we_cyc, 16 + T_WP);
        run_req(1'b0, 20'h00060, 2'd1, 2'b11, 16'h0, 1'b0);
        chk(rd_dat[0] == 16'hBEEF, "R11 written word", rd_dat[0], 16'hBEEF);
        chk(rd_dat[1] == pat(20'h00061), "R11 next word untouched", rd_dat[1], pat(20'h00061));

        // R1 idle again
        chk(req_ready && mem_ce_n && mem_sleep_n, "R1 idle after traffic",
            {req_ready, mem_ce_n, mem_sleep_n}, 3'b111);

        finished = 1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors + wd_err);
        $finish;
    end
endmodule